// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps time of day and calendar date in packed BCD: seconds, minutes, hours (24-hour), day of week, day of month, month, two-digit year and a century count. A free-running set of counters advances once per second. The second is derived by dividing a 32.768 kHz oscillator enable. Software never touches those counters directly. It sees a second, user-facing copy of every field, refreshed from the counters each second.

Two control bits freeze the user copy. The hold-for-read bit lets software read all fields coherently while the counters keep running. The hold-for-load bit lets software write a new time and date. Clearing it moves the loaded values into the counters and restarts the second divider. A stop bit halts the oscillator divider. A frequency-test bit, gated by an external alarm-enable level and the watchdog state, routes a 512 Hz square wave to an output for measuring the crystal.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the fields are 00:00:00, day 01, date 01, month 01, year 00 and century 20. The hold bits and the frequency-test bit are 0 and the oscillator runs. Register map by `reg_addr`: 0 = control {bit7 hold-for-load, bit6 hold-for-read, bits5:0 century}, 1 = seconds {bit7 stop}, 2 = minutes, 3 = hours, 4 = day of week {bit6 frequency-test, bits2:0 day}, 5 = date, 6 = month, 7 = year.
- R2: While running, `sec_tick` pulses for one clock after every 2^DIV_BITS `osc_tick` pulses, and the counters advance by one second on that pulse.
- R3: Seconds and minutes wrap 59→00, hours 23→00, day of week 07→01, month 12→01, and year 99→00. The year wrap carries into the century, which wraps 39→00.
- R4: The date wraps to 01 after 30 in April, June, September and November, after 31 in the other long months, and after 29 in February when the BCD year is a multiple of 4, otherwise after 28.
- R5: With both hold bits 0, the user copy reloads from the counters one clock after each `sec_tick`.
- R6: While hold-for-read is 1 the user copy does not change, but the counters keep advancing. The first `sec_tick` after the bit clears shows the advanced count.
- R7: While hold-for-load is 1 the user copy is not refreshed. Writes to the time and date fields, and to the century field, take effect only while hold-for-load is 1, or in the same write that sets it for the century. Otherwise they are ignored.
- R8: A control write that clears a set hold-for-load bit copies the user copy into the counters one clock later and restarts the second divider from zero.
- R9: Seconds bit 7 is a stop bit that can be written at any time. While it is 1, the divider holds and neither `sec_tick` nor the counters move.
- R10: `freq_test_out` is a square wave from divider bit DIV_BITS-10 (512 Hz at the default). It is driven only when the frequency-test bit is 1, `alarm_int_en` is 0, and `wdog_steer` or `wdog_zero` is 1; otherwise it is held at 0. The frequency-test bit can be written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-clock enable per 32.768 kHz oscillator period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| alarm_int_en | input | 1 | Alarm interrupt enable level; 1 blocks the test output |
| wdog_steer | input | 1 | Watchdog steering bit |
| wdog_zero | input | 1 | Watchdog register equals zero |
| sec_tick | output | 1 | One-second pulse |
| freq_test_out | output | 1 | Frequency-test square wave |

## Verification
A wrong carry or month-length decision in the counters does not reach `reg_rdata` until the tick after it happens. It then shows up one clock after that tick, when the user copy reloads. For that reason the bench presets values just before each rollover and reads them back after a single tick. A broken hold or commit path shows within one second: fields that move while held, or loaded values that never reach the counters. A divider fault shows at once in the spacing of `sec_tick` and the toggling of `freq_test_out`.

// File: rtl/rtc_cal_pkg.sv
// Shared calendar types and BCD helpers.
// Assumes all fields hold valid packed BCD.
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] century;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{century: 8'h20, year: 8'h00, month: 8'h01,
                                   date: 8'h01, day: 8'h01, hour: 8'h00,
                                   min: 8'h00, sec: 8'h00};

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_SEC   = 3'd1;
    localparam logic [2:0] A_MIN   = 3'd2;
    localparam logic [2:0] A_HOUR  = 3'd3;
    localparam logic [2:0] A_DAY   = 3'd4;
    localparam logic [2:0] A_DATE  = 3'd5;
    localparam logic [2:0] A_MONTH = 3'd6;
    localparam logic [2:0] A_YEAR  = 3'd7;

    // Add one to a two-digit BCD value
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last date of a month, leap year when the year is a multiple of 4
    function automatic logic [7:0] month_last(input logic [7:0] month,
                                              input logic [7:0] year);
        logic [7:0] ybin;
        ybin = ({4'd0, year[7:4]} * 8'd10) + {4'd0, year[3:0]};
        case (month)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the oscillator enable down to a one-second pulse and taps the
// 512 Hz test wave. Assumes osc_tick is already synchronous to clk.
module rtc_prescaler #(
    parameter int DIV_BITS = 15,
    parameter int FT_TAP   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic run,
    input  logic restart,
    output logic sec_tick,
    output logic ft_wave
);
    logic [DIV_BITS-1:0] div_q;

    // Divider: counts oscillator enables while running, zeroed on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_q <= '0;
        else if (run && osc_tick) div_q <= div_q + 1'b1;
    end

    assign sec_tick = run && osc_tick && (&div_q);
    assign ft_wave  = div_q[FT_TAP];
endmodule

// File: rtl/rtc_time_counter.sv
// Always-running BCD time and calendar counters with a parallel load.
// Assumes loaded values are valid BCD within their ranges.
module rtc_time_counter
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cal_t load_val,
    output cal_t cal
);
    cal_t nxt;

    // Next-second value with full carry chain
    always_comb begin
        nxt     = cal;
        nxt.sec = bcd_inc(cal.sec);
        if (cal.sec == 8'h59) begin
            nxt.sec = 8'h00;
            nxt.min = bcd_inc(cal.min);
            if (cal.min == 8'h59) begin
                nxt.min  = 8'h00;
                nxt.hour = bcd_inc(cal.hour);
                if (cal.hour == 8'h23) begin
                    nxt.hour = 8'h00;
                    nxt.day  = (cal.day == 8'h07) ? 8'h01 : bcd_inc(cal.day);
                    nxt.date = bcd_inc(cal.date);
                    if (cal.date == month_last(cal.month, cal.year)) begin
                        nxt.date  = 8'h01;
                        nxt.month = bcd_inc(cal.month);
                        if (cal.month == 8'h12) begin
                            nxt.month = 8'h01;
                            nxt.year  = bcd_inc(cal.year);
                            if (cal.year == 8'h99) begin
                                nxt.year    = 8'h00;
                                nxt.century = (cal.century == 8'h39) ? 8'h00
                                                                     : bcd_inc(cal.century);
                            end
                        end
                    end
                end
            end
        end
    end

    // Counter state: load has priority over the tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cal <= CAL_RESET;
        else if (load) cal <= load_val;
        else if (tick) cal <= nxt;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
// Calendar clock top: user-facing register copy, hold bits, commit path,
// oscillator stop and frequency-test gating. Assumes DIV_BITS >= 10 and
// that bus decode happens outside this block.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       alarm_int_en,
    input  logic       wdog_steer,
    input  logic       wdog_zero,
    output logic       sec_tick,
    output logic       freq_test_out
);
    localparam int FT_TAP = DIV_BITS - 10;

    cal_t ext_q;
    cal_t int_cal;
    logic hold_load, hold_read, osc_stop, ft_bit, commit_pend, tick_q;
    logic ft_wave;

    rtc_prescaler #(.DIV_BITS(DIV_BITS), .FT_TAP(FT_TAP)) u_div (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run(!osc_stop),
        .restart(commit_pend), .sec_tick(sec_tick), .ft_wave(ft_wave)
    );

    rtc_time_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(commit_pend),
        .load_val(ext_q), .cal(int_cal)
    );

    // Delay the tick one clock so the reload sees the advanced counters
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= sec_tick;
    end

    // User copy, control bits and register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q       <= CAL_RESET;
            hold_load   <= 1'b0;
            hold_read   <= 1'b0;
            osc_stop    <= 1'b0;
            ft_bit      <= 1'b0;
            commit_pend <= 1'b0;
        end else begin
            commit_pend <= 1'b0;
            if (tick_q && !hold_load && !hold_read) ext_q <= int_cal;
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL: begin
                        if (hold_load || reg_wdata[7])
                            ext_q.century <= {2'b00, reg_wdata[5:0]};
                        hold_load   <= reg_wdata[7];
                        hold_read   <= reg_wdata[6];
                        commit_pend <= hold_load && !reg_wdata[7];
                    end
                    A_SEC: begin
                        osc_stop <= reg_wdata[7];
                        if (hold_load) ext_q.sec <= {1'b0, reg_wdata[6:0]};
                    end
                    A_MIN:   if (hold_load) ext_q.min   <= {1'b0, reg_wdata[6:0]};
                    A_HOUR:  if (hold_load) ext_q.hour  <= {2'b00, reg_wdata[5:0]};
                    A_DAY: begin
                        ft_bit <= reg_wdata[6];
                        if (hold_load) ext_q.day <= {5'd0, reg_wdata[2:0]};
                    end
                    A_DATE:  if (hold_load) ext_q.date  <= {2'b00, reg_wdata[5:0]};
                    A_MONTH: if (hold_load) ext_q.month <= {3'd0, reg_wdata[4:0]};
                    default: if (hold_load) ext_q.year  <= reg_wdata;
                endcase
            end
        end
    end

    // Read mux over the user copy and control bits
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {hold_load, hold_read, ext_q.century[5:0]};
            A_SEC:   reg_rdata = {osc_stop, ext_q.sec[6:0]};
            A_MIN:   reg_rdata = ext_q.min;
            A_HOUR:  reg_rdata = ext_q.hour;
            A_DAY:   reg_rdata = {1'b0, ft_bit, 3'b000, ext_q.day[2:0]};
            A_DATE:  reg_rdata = ext_q.date;
            A_MONTH: reg_rdata = ext_q.month;
            default: reg_rdata = ext_q.year;
        endcase
    end

    // Frequency-test gating
    assign freq_test_out = ft_bit && !alarm_int_en && (wdog_steer || wdog_zero) && ft_wave;
endmodule

// File: rtl/rtc_calendar_checks.sv
// Temporal checks on the calendar core, attached by bind.
module rtc_calendar_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       osc_stop,
    input logic       ft_bit,
    input logic       freq_test_out,
    input logic       hold_read,
    input logic       hold_load,
    input logic       reg_wr,
    input logic       tick_q,
    input logic       commit_pend,
    input logic [7:0] ext_sec,
    input logic [7:0] int_sec
);
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R2
    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && !hold_read && !hold_load && !reg_wr) |=> (ext_sec == $past(int_sec))); // R5
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_read && !reg_wr) |=> $stable(ext_sec)); // R6
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pend |=> (int_sec == $past(ext_sec))); // R8
    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |-> !sec_tick); // R9
    AST_FT_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ft_bit |-> !freq_test_out); // R10
endmodule

bind rtc_calendar_core rtc_calendar_checks u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_stop(osc_stop),
    .ft_bit(ft_bit), .freq_test_out(freq_test_out), .hold_read(hold_read),
    .hold_load(hold_load), .reg_wr(reg_wr), .tick_q(tick_q),
    .commit_pend(commit_pend), .ext_sec(ext_q.sec), .int_sec(int_cal.sec)
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
    localparam int CLK_PERIOD  = 10;
    localparam int DIV_BITS    = 10;
    localparam int TICK_CYCLES = 1 << DIV_BITS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       alarm_int_en = 1'b0;
    logic       wdog_steer = 1'b1;
    logic       wdog_zero = 1'b0;
    logic       sec_tick;
    logic       freq_test_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    rtc_calendar_core #(.DIV_BITS(DIV_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_int_en(alarm_int_en), .wdog_steer(wdog_steer), .wdog_zero(wdog_zero),
        .sec_tick(sec_tick), .freq_test_out(freq_test_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog R2 got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        do_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!sec_tick) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic count_toggles(input int n, output int c);
        logic prev;
        c = 0;
        @(negedge clk);
        prev = freq_test_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (freq_test_out !== prev) c++;
            prev = freq_test_out;
        end
    endtask

    // Load a full time with hold-for-load, optionally checking the freeze, then commit
    task automatic set_time(input logic [7:0] cen, yr, mo, dt, dy, hr, mi, se,
                            input bit check_hold);
        do_write(3'd0, 8'h80 | cen);
        do_write(3'd1, se);
        do_write(3'd2, mi);
        do_write(3'd3, hr);
        do_write(3'd4, dy);
        do_write(3'd5, dt);
        do_write(3'd6, mo);
        do_write(3'd7, yr);
        if (check_hold) begin
            wait_tick();
            expect_reg("R7 hold-for-load keeps loaded seconds", 3'd1, se);
            expect_reg("R7 hold-for-load keeps loaded year", 3'd7, yr);
        end
        do_write(3'd0, cen & 8'h3F);
    endtask

    task automatic t_reset();
        expect_reg("R1 reset control", 3'd0, 8'h20);
        expect_reg("R1 reset seconds", 3'd1, 8'h00);
        expect_reg("R1 reset minutes", 3'd2, 8'h00);
        expect_reg("R1 reset hours", 3'd3, 8'h00);
        expect_reg("R1 reset day", 3'd4, 8'h01);
        expect_reg("R1 reset date", 3'd5, 8'h01);
        expect_reg("R1 reset month", 3'd6, 8'h01);
        expect_reg("R1 reset year", 3'd7, 8'h00);
        check("R1 reset test output", freq_test_out, 1'b0);
    endtask

    task automatic t_tick_rate();
        int gap;
        wait_tick();
        expect_reg("R5 seconds reloaded after tick", 3'd1, 8'h01);
        @(negedge clk);
        while (!sec_tick) @(negedge clk);
        gap = 0;
        @(negedge clk);
        gap++;
        while (!sec_tick) begin @(negedge clk); gap++; end
        check("R2 tick spacing", gap, TICK_CYCLES);
        repeat (3) @(negedge clk);
        expect_reg("R2 seconds after tick", 3'd1, 8'h03);
    endtask

    task automatic t_rollover();
        set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 1'b1);
        wait_tick();
        expect_reg("R3 century carry", 3'd0, 8'h20);
        expect_reg("R3 seconds wrap", 3'd1, 8'h00);
        expect_reg("R3 minutes wrap", 3'd2, 8'h00);
        expect_reg("R3 hours wrap", 3'd3, 8'h00);
        expect_reg("R3 day wrap", 3'd4, 8'h01);
        expect_reg("R8 committed date wrap", 3'd5, 8'h01);
        expect_reg("R3 month wrap", 3'd6, 8'h01);
        expect_reg("R3 year wrap", 3'd7, 8'h00);
    endtask

    task automatic t_leap();
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, 1'b0);
        wait_tick();
        expect_reg("R4 leap Feb 29 date", 3'd5, 8'h29);
        expect_reg("R4 leap Feb 29 month", 3'd6, 8'h02);
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59, 1'b0);
        wait_tick();
        expect_reg("R4 leap Feb end date", 3'd5, 8'h01);
        expect_reg("R4 leap Feb end month", 3'd6, 8'h03);
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 1'b0);
        wait_tick();
        expect_reg("R4 common Feb end date", 3'd5, 8'h01);
        expect_reg("R4 common Feb end month", 3'd6, 8'h03);
        set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59, 1'b0);
        wait_tick();
        expect_reg("R4 April end date", 3'd5, 8'h01);
        expect_reg("R4 April end month", 3'd6, 8'h05);
        set_time(8'h20, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 1'b0);
        wait_tick();
        expect_reg("R4 January 31 exists", 3'd5, 8'h31);
    endtask

    task automatic t_read_hold();
        set_time(8'h20, 8'h23, 8'h06, 8'h15, 8'h04, 8'h10, 8'h20, 8'h30, 1'b0);
        wait_tick();
        expect_reg("R5 seconds after commit", 3'd1, 8'h31);
        do_write(3'd0, 8'h40);
        expect_reg("R7 century ignored without hold-for-load", 3'd0, 8'h60);
        wait_tick();
        wait_tick();
        expect_reg("R6 frozen seconds", 3'd1, 8'h31);
        do_write(3'd0, 8'h00);
        wait_tick();
        expect_reg("R6 counters ran during hold", 3'd1, 8'h34);
    endtask

    task automatic t_ignored_writes();
        do_write(3'd2, 8'h45);
        expect_reg("R7 minute write ignored", 3'd2, 8'h20);
        do_write(3'd7, 8'h77);
        expect_reg("R7 year write ignored", 3'd7, 8'h23);
    endtask

    task automatic t_osc_stop();
        int ticks = 0;
        do_write(3'd1, 8'h80);
        expect_reg("R9 stop bit reads back", 3'd1, 8'hB4);
        for (int i = 0; i < 2 * TICK_CYCLES + 10; i++) begin
            @(negedge clk);
            if (sec_tick) ticks++;
        end
        check("R9 no ticks while stopped", ticks, 0);
        expect_reg("R9 seconds frozen while stopped", 3'd1, 8'hB4);
        do_write(3'd1, 8'h00);
        expect_reg("R9 restart keeps seconds", 3'd1, 8'h34);
        wait_tick();
        expect_reg("R9 counting resumes", 3'd1, 8'h35);
    endtask

    task automatic t_freq_test();
        int c;
        do_write(3'd4, 8'h40);
        expect_reg("R10 test bit set, day kept", 3'd4, 8'h44);
        count_toggles(20, c);
        check("R10 wave with steer bit", c, 20);
        alarm_int_en = 1'b1;
        count_toggles(20, c);
        check("R10 blocked by alarm enable", c, 0);
        check("R10 blocked level", freq_test_out, 1'b0);
        alarm_int_en = 1'b0;
        wdog_steer = 1'b0;
        count_toggles(20, c);
        check("R10 blocked by active watchdog", c, 0);
        wdog_zero = 1'b1;
        count_toggles(20, c);
        check("R10 wave with watchdog zero", c, 20);
        do_write(3'd4, 8'h00);
        count_toggles(20, c);
        check("R10 test bit cleared", c, 0);
    endtask

    task automatic t_reset_clears_ft();
        int c;
        do_write(3'd4, 8'h40);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_reg("R1 reset clears test bit", 3'd4, 8'h01);
        count_toggles(20, c);
        check("R1 test output quiet after reset", c, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick_rate();
        t_rollover();
        t_leap();
        t_read_hold();
        t_ignored_writes();
        t_osc_stop();
        t_freq_test();
        t_reset_clears_ft();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule